// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Engine

This block is a clocked, synthesizable model of the write path of a byte-wide electrically erasable memory. The memory sits behind an asynchronous parallel bus with active-low select, write and output strobes. A host stores bytes by pulsing the strobes. The block collects those bytes into a page buffer. Every new byte, and every fresh write strobe, restarts a load window. When the window runs out without being retriggered, an internal programming period starts. At the end of that period the whole page is copied into the register-array memory in one step.

While programming is in progress, the block shows a busy output. A read of the byte that was loaded last returns a status pattern, which lets a host poll for completion. Writes are locked out for a settling time after the supply becomes valid, and also whenever the supply is flagged bad. The load window, the programming time and the settling time are parameters counted in clock cycles. All strobes, the address and the data pass through two-flop synchronizers before any edge is detected.

Top module: `page_write_engine`

## Requirements
- R1: After reset, busy is low, rdData is 0 while no read is selected, and every array byte reads 0xFF (erased). A write cycle ends and is discarded when it completes before supplyOk has been high for POR_CYC cycles.
- R2: A byte is accepted only from a cycle in which oeN is high while csN and weN are both low. A cycle run with oeN held low leaves the array unchanged and never raises busy.
- R3: The address is taken when the later of csN and weN goes low. The data is taken when the earlier of the two goes high. Address and data changes at other moments have no effect.
- R4: Each accepted byte, and each falling edge of weN during loading, restarts a load window of LOAD_CYC cycles. busy rises only after the window expires.
- R5: Loaded bytes appear in the array only when programming ends, and all of them appear together. Page offsets that were not loaded keep their earlier contents.
- R6: busy stays high for exactly PROG_CYC cycles, whatever number of bytes the page holds.
- R7: A read is selected by csN low, oeN low and weN high. While busy is high, a read of the last loaded address returns that byte with bit 7 inverted and the other bits true. After programming, the same read returns the true byte.
- R8: Byte cycles that complete while busy is high are discarded. They neither change the array nor start a new page.
- R9: The page row, which is the address above the low PAGE_BITS bits, is fixed by the first byte of a page. Later bytes land at their own low offset inside that row, whatever their upper address bits are.
- R10: While supplyOk is low, no byte is accepted. When supplyOk returns, the POR_CYC lockout starts again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supplyOk | input | 1 | High while the supply is valid |
| csN | input | 1 | Chip select, active low, asynchronous |
| weN | input | 1 | Write strobe, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Byte address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data; 0 when no read is selected |
| busy | output | 1 | High during the internal programming period |

## Verification
The checks assume that the bus changes slowly compared with the clock. Every strobe level is held for at least three clock cycles, and address and data stay stable around each strobe edge, so that the synchronized copies line up. They also assume that the bytes of a page follow each other more closely than LOAD_CYC cycles. The bench drives all inputs on falling clock edges. It holds every strobe phase for four cycles and spaces the bytes of a page about a dozen cycles apart, against a load window of forty cycles. This keeps the stimulus inside those assumptions. The tests that move the address or data in the middle of a cycle do so only while both strobes are low, which is the case R3 defines.

// File: rtl/pwe_pkg.sv
package pwe_pkg;
  typedef struct packed {
    logic capAddr;
    logic loadByte;
    logic commit;
    logic progActive;
    logic readEn;
  } pweStrobes_t;
endpackage

// File: rtl/pwe_ctrl.sv
module pwe_ctrl #(
  parameter int LOAD_CYC = 18750,
  parameter int PROG_CYC = 750000,
  parameter int POR_CYC  = 625000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic csN,
  input  logic weN,
  input  logic oeN,
  output pwe_pkg::pweStrobes_t strb,
  output logic busy
);
  localparam int LW = $clog2(LOAD_CYC + 1);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam int RW = $clog2(POR_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} state_t;

  logic [3:0] syncA, syncB;
  logic csS, weS, oeS, supS, weSPrev;
  logic cycOpen, unlocked, bothLow, startCyc, endCyc, weFall, loadOk;
  logic [RW-1:0] porCnt;
  logic [LW-1:0] loadTmr;
  logic [PW-1:0] progTmr;
  state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 4'b0111;
      syncB <= 4'b0111;
    end else begin
      syncA <= {supplyOk, oeN, weN, csN};
      syncB <= syncA;
    end
  end

  assign csS = syncB[0];
  assign weS = syncB[1];
  assign oeS = syncB[2];
  assign supS = syncB[3];

  assign unlocked = supS && (porCnt == RW'(POR_CYC));
  assign bothLow  = !csS && !weS;
  assign startCyc = bothLow && oeS && unlocked && !cycOpen;
  assign endCyc   = cycOpen && !bothLow;
  assign weFall   = weSPrev && !weS;
  assign loadOk   = endCyc && oeS && unlocked && (state != ST_PROG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      porCnt  <= '0;
      cycOpen <= 1'b0;
      weSPrev <= 1'b1;
    end else begin
      weSPrev <= weS;
      if (!supS) porCnt <= '0;
      else if (porCnt != RW'(POR_CYC)) porCnt <= porCnt + 1'b1;
      if (startCyc) cycOpen <= 1'b1;
      else if (endCyc || !oeS) cycOpen <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      loadTmr <= '0;
      progTmr <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (loadOk) begin
          state   <= ST_LOAD;
          loadTmr <= '0;
        end
        ST_LOAD: begin
          if (loadOk || weFall) loadTmr <= '0;
          else if (loadTmr == LW'(LOAD_CYC - 1)) begin
            state   <= ST_PROG;
            progTmr <= '0;
          end else loadTmr <= loadTmr + 1'b1;
        end
        ST_PROG: begin
          if (progTmr == PW'(PROG_CYC - 1)) state <= ST_IDLE;
          else progTmr <= progTmr + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy            = (state == ST_PROG);
  assign strb.capAddr    = startCyc;
  assign strb.loadByte   = loadOk;
  assign strb.commit     = busy && (progTmr == PW'(PROG_CYC - 1));
  assign strb.progActive = busy;
  assign strb.readEn     = !csS && !oeS && weS;
endmodule

// File: rtl/pwe_datapath.sv
module pwe_datapath #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_BITS = 7,
  parameter int DATA_W    = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  pwe_pkg::pweStrobes_t strb,
  output logic [DATA_W-1:0] rdData
);
  localparam int PAGE_SZ = 1 << PAGE_BITS;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int ROW_W   = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0] addrP1, addrP2, curAddr, lastAddr;
  logic [DATA_W-1:0] dataP1, dataP2, lastData;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] pageBuf [PAGE_SZ];
  logic [PAGE_SZ-1:0] pageValid;
  logic [ROW_W-1:0] pageRow, effRow;
  logic [PAGE_BITS-1:0] curOff;

  assign curOff = curAddr[PAGE_BITS-1:0];
  assign effRow = (|pageValid) ? pageRow : curAddr[ADDR_W-1:PAGE_BITS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrP1 <= '0; addrP2 <= '0;
      dataP1 <= '0; dataP2 <= '0;
      curAddr <= '0;
    end else begin
      addrP1 <= addr;   addrP2 <= addrP1;
      dataP1 <= wrData; dataP2 <= dataP1;
      if (strb.capAddr) curAddr <= addrP2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      for (int i = 0; i < PAGE_SZ; i++) pageBuf[i] <= '1;
      pageValid <= '0;
      pageRow   <= '0;
      lastAddr  <= '0;
      lastData  <= '0;
      rdData    <= '0;
    end else begin
      if (strb.loadByte) begin
        pageBuf[curOff]   <= dataP2;
        pageValid[curOff] <= 1'b1;
        pageRow           <= effRow;
        lastAddr          <= {effRow, curOff};
        lastData          <= dataP2;
      end
      if (strb.commit) begin
        for (int i = 0; i < PAGE_SZ; i++)
          if (pageValid[i]) mem[{pageRow, PAGE_BITS'(i)}] <= pageBuf[i];
        pageValid <= '0;
      end
      if (!strb.readEn) rdData <= '0;
      else if (strb.progActive && addrP2 == lastAddr)
        rdData <= {~lastData[DATA_W-1], lastData[DATA_W-2:0]};
      else rdData <= mem[addrP2];
    end
  end
endmodule

// File: rtl/page_write_engine.sv
module page_write_engine #(
  parameter int ADDR_W    = 10,
  parameter int PAGE_BITS = 7,
  parameter int DATA_W    = 8,
  parameter int LOAD_CYC  = 18750,
  parameter int PROG_CYC  = 750000,
  parameter int POR_CYC   = 625000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyOk,
  input  logic csN,
  input  logic weN,
  input  logic oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic busy
);
  pwe_pkg::pweStrobes_t strb;

  pwe_ctrl #(.LOAD_CYC(LOAD_CYC), .PROG_CYC(PROG_CYC), .POR_CYC(POR_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .csN(csN), .weN(weN),
    .oeN(oeN), .strb(strb), .busy(busy)
  );

  pwe_datapath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .strb(strb),
    .rdData(rdData)
  );
endmodule

// File: rtl/pwe_checker.sv
module pwe_checker #(
  parameter int PROG_CYC = 750000
) (
  input logic clk,
  input logic rstN,
  input logic supplyOk,
  input logic oeN,
  input logic busy,
  input pwe_pkg::pweStrobes_t strb
);
  localparam int BW = $clog2(PROG_CYC + 2);
  logic [BW-1:0] busyLen;

  always_ff @(posedge clk) begin
    if (!rstN) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  a_r6_prog_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyLen == BW'(PROG_CYC));

  a_r2_oe_high_for_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadByte |-> $past(oeN, 2));

  a_r10_no_load_supply_low: assert property (@(posedge clk) disable iff (!rstN)
    !$past(supplyOk, 2) |-> !strb.loadByte);

  a_r8_no_load_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.loadByte);

  a_r5_commit_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !busy);

  a_r5_busy_ends_by_commit: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(strb.commit));
endmodule

bind page_write_engine pwe_checker #(.PROG_CYC(PROG_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .oeN(oeN), .busy(busy),
  .strb(strb)
);

// File: tb/page_write_engine_bench.sv
module page_write_engine_bench;
  localparam int AW = 10, PB = 4, DW = 8;
  localparam int LOAD = 40, PROG = 60, POR = 30;

  logic clk = 1'b0, rstN = 1'b0, supplyOk = 1'b0;
  logic csN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic busy;
  int checks = 0, failures = 0, busyRun = 0, lastRun = 0;
  bit done = 0;

  always #4 clk = ~clk;

  page_write_engine #(.ADDR_W(AW), .PAGE_BITS(PB), .DATA_W(DW),
    .LOAD_CYC(LOAD), .PROG_CYC(PROG), .POR_CYC(POR)) u_page_write_engine (
    .clk(clk), .rstN(rstN), .supplyOk(supplyOk), .csN(csN), .weN(weN),
    .oeN(oeN), .addr(addr), .wrData(wrData), .rdData(rdData), .busy(busy)
  );

  always @(negedge clk) begin
    if (busy) busyRun++;
    else if (busyRun != 0) begin lastRun = busyRun; busyRun = 0; end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wrData = d; csN = 0; weN = 0;
    idle(4); weN = 1;
    idle(4); csN = 1;
    idle(2);
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic [DW-1:0] q);
    @(negedge clk); addr = a; csN = 0; oeN = 0;
    idle(6); q = rdData;
    oeN = 1; csN = 1;
    idle(3);
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 400 && busy; k++) @(negedge clk);
  endtask

  task automatic expectByte(input string req, input logic [AW-1:0] a, input logic [DW-1:0] e);
    logic [DW-1:0] q;
    doRead(a, q);
    check(req, q, e);
  endtask

  task automatic testResetLockout();
    idle(1);
    check("R1 busy after reset", busy, 0);
    check("R1 rdData idle", rdData, 0);
    doWrite(10'h005, 8'h12);
    idle(LOAD + PROG + 20);
    check("R1 no programming during lockout", lastRun, 0);
    expectByte("R1 locked write discarded", 10'h005, 8'hFF);
  endtask

  task automatic testSupplyLow();
    supplyOk = 0; idle(4);
    doWrite(10'h006, 8'h34);
    idle(LOAD + 10);
    check("R10 no load with supply low", busy, 0);
    supplyOk = 1;
    doWrite(10'h007, 8'h56);
    idle(LOAD + PROG + 20);
    check("R10 lockout restarts", lastRun, 0);
    expectByte("R10 addr 6", 10'h006, 8'hFF);
    expectByte("R10 addr 7", 10'h007, 8'hFF);
    idle(POR);
  endtask

  task automatic testOeInhibit();
    @(negedge clk); addr = 10'h008; wrData = 8'h9A; oeN = 0; idle(2);
    csN = 0; weN = 0; idle(4); weN = 1; idle(4); csN = 1; idle(2); oeN = 1;
    idle(LOAD + 10);
    check("R2 oe low never busy", busy, 0);
    expectByte("R2 oe low write discarded", 10'h008, 8'hFF);
  endtask

  task automatic testPage();
    logic [DW-1:0] q;
    for (int i = 0; i < 4; i++) doWrite(AW'(10'h020 + i), DW'(8'hA0 + i));
    idle(30);
    check("R4 window still open", busy, 0);
    idle(15);
    check("R4 programming after window", busy, 1);
    doRead(10'h023, q);
    check("R7 polling pattern", q, 8'h23);
    expectByte("R5 not visible while busy", 10'h020, 8'hFF);
    doWrite(10'h050, 8'h77);
    waitIdle();
    idle(2);
    check("R6 busy length 4-byte page", lastRun, PROG);
    for (int i = 0; i < 4; i++) expectByte("R5 page byte", AW'(10'h020 + i), DW'(8'hA0 + i));
    expectByte("R5 unloaded offset kept", 10'h024, 8'hFF);
    expectByte("R7 true data after", 10'h023, 8'hA3);
    idle(LOAD + 10);
    check("R8 no page from busy write", busy, 0);
    expectByte("R8 busy write discarded", 10'h050, 8'hFF);
  endtask

  task automatic testCaptureEdges();
    @(negedge clk); addr = 10'h031; wrData = 8'h11; csN = 0; weN = 0;
    idle(4); addr = 10'h03F; wrData = 8'h5C;
    idle(4); weN = 1; idle(4); csN = 1; idle(2);
    @(negedge clk); addr = 10'h032; wrData = 8'h00; weN = 0;
    idle(4); addr = 10'h033; wrData = 8'h66; csN = 0;
    idle(4); csN = 1; idle(1); wrData = 8'h99;
    idle(4); weN = 1; idle(2);
    doWrite(10'h045, 8'h4E);
    idle(LOAD + 5);
    waitIdle();
    idle(2);
    check("R6 busy length 3-byte page", lastRun, PROG);
    expectByte("R3 addr at fall, data at rise", 10'h031, 8'h5C);
    expectByte("R3 late address ignored", 10'h03F, 8'hFF);
    expectByte("R3 cs-controlled cycle", 10'h033, 8'h66);
    expectByte("R3 early address ignored", 10'h032, 8'hFF);
    expectByte("R9 byte lands in first row", 10'h035, 8'h4E);
    expectByte("R9 other row untouched", 10'h045, 8'hFF);
  endtask

  initial begin
    idle(3);
    rstN = 1; supplyOk = 1;
    testResetLockout();
    testSupplyLow();
    testOeInhibit();
    testPage();
    testCaptureEdges();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule